// File: doc/BRIEF.md
# Interrupt Pin Capture and Dispatch Engine

This block watches a bank of interrupt input lines and remembers which of them need service. Each line has a configuration entry that arrives on input ports: a mask bit, a trigger kind (edge or level), a polarity flag, a destination, a destination addressing flag, a delivery mode and a vector. A rising input marks its pin pending and wakes a scanner. The scanner walks the pins from the lowest index to the highest. For every pending pin that is not masked, it raises one delivery request carrying that pin's entry to a downstream message bus.

The bus takes a request with a valid/ready handshake. It then answers with a single response pulse that either accepts or rejects the message. Only one request is in flight at a time. The response decides three things: whether the pending bit is dropped, the value of the per-pin delivery-status flag, and whether a shared retry counter resets or grows. A write to the configuration table is signalled by a one-cycle pulse, which also starts a scan. This lets software re-attempt deliveries that were rejected or masked.

Top module: `irq_dispatch`

## Requirements
- R1: After reset every pending bit, every delivery-status bit, the retry count, the stall warning, the external-mode error and req_valid are all zero.
- R2: When a pin configured as level-triggered (cfg_level bit = 1) sees its input go from 1 to 0, its pending bit is 0 from the next cycle. This holds whether or not the pin is masked.
- R3: When a pin configured as edge-triggered (cfg_level bit = 0) sees its input go from 1 to 0, its pending bit keeps its value.
- R4: A 0-to-1 change on any input sets that pin's pending bit and starts a scan. The scan visits pins in ascending index order and issues at most one request at a time. Each request carries the visited pin's index, vector, destination, mode, addressing flag, polarity and trigger kind.
- R5: A pin whose mask bit is 1 is never requested, and its pending bit is left as it is.
- R6: An accept response clears that pin's delivery-status bit and returns the retry count to 0. It clears the pending bit of an edge-triggered pin and leaves the pending bit of a level-triggered pin set.
- R7: A reject response sets that pin's delivery-status bit and leaves its pending bit set. It raises the retry count by one, and the count saturates at its maximum value. stall_warn is 1 exactly when the count is greater than 5.
- R8: A pending, unmasked pin whose 3-bit delivery mode equals 7 is not requested. Its visit produces a one-cycle pulse on extint_err, and its pending bit stays set.
- R9: A one-cycle pulse on cfg_write starts a scan even when no input has changed.
- R10: If an edge-triggered pin's input rises in the same cycle as the accept response for that pin, its pending bit stays set, and a further scan requests it again.
- R11: While req_valid is 1 and req_ready is 0, req_valid stays 1 and the request fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Interrupt input levels, 1 = active |
| cfg_write | input | 1 | One-cycle pulse after a configuration table write; starts a scan |
| cfg_mask | input | NUM_PINS | 1 = pin masked |
| cfg_level | input | NUM_PINS | 1 = level-triggered, 0 = edge-triggered |
| cfg_polarity | input | NUM_PINS | Polarity flag forwarded with the request |
| cfg_logical | input | NUM_PINS | Destination addressing flag forwarded with the request |
| cfg_dmode | input | 3*NUM_PINS | Delivery mode per pin; pin i uses bits [3i+2:3i] |
| cfg_vector | input | VEC_W*NUM_PINS | Vector per pin; pin i uses slice i |
| cfg_dest | input | DEST_W*NUM_PINS | Destination per pin; pin i uses slice i |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Bus takes the request |
| req_pin | output | PIN_W | Index of the requested pin |
| req_vector | output | VEC_W | Vector of the requested pin |
| req_dest | output | DEST_W | Destination of the requested pin |
| req_dmode | output | 3 | Delivery mode of the requested pin |
| req_logical | output | 1 | Addressing flag of the requested pin |
| req_polarity | output | 1 | Polarity flag of the requested pin |
| req_level | output | 1 | Trigger kind of the requested pin |
| rsp_valid | input | 1 | One-cycle response for the request in flight |
| rsp_accept | input | 1 | 1 = accepted, 0 = rejected (read with rsp_valid) |
| pending | output | NUM_PINS | Pending bits |
| dlv_status | output | NUM_PINS | Delivery-status bits, 1 = last attempt rejected |
| stall_count | output | STALL_W | Saturating retry count |
| stall_warn | output | 1 | Retry count above 5 |
| extint_err | output | 1 | One-cycle pulse for a visit to an unsupported mode-7 entry |

## Verification
Input event tracking and response handling both write the pending register. The sharpest overlap is a fresh rising edge on an edge-triggered pin arriving in the very cycle its accept response lands. The bench provokes this by dropping the line while the request is in flight, then raising it again together with the accept pulse. It then requires the pending bit to survive and the pin to be requested once more by the scan that the edge queued. A second overlap, a level pin falling while masked, is judged by watching the pending output on the following cycle.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    localparam int unsigned DMODE_W = 3;
    localparam logic [DMODE_W-1:0] DMODE_EXTINT = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_REQ  = 2'd2,
        ST_WAIT = 2'd3
    } scan_state_e;

endpackage

// File: rtl/irq_level_track.sv
module irq_level_track #(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] rise,
    output logic [NUM_PINS-1:0] fall
);

    logic [NUM_PINS-1:0] level_d, level_q;

    always_comb begin
        level_d = pin_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign rise[i] = pin_in[i] & ~level_q[i];
        assign fall[i] = ~pin_in[i] & level_q[i];
    end

endmodule

// File: rtl/irq_stall_count.sv
module irq_stall_count #(
    parameter int unsigned STALL_W     = 4,
    parameter int unsigned STALL_LIMIT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bump,
    input  logic               clear,
    output logic [STALL_W-1:0] count,
    output logic               warn
);

    localparam logic [STALL_W-1:0] CNT_MAX = {STALL_W{1'b1}};
    localparam logic [STALL_W-1:0] CNT_LIM = STALL_W'(STALL_LIMIT);

    logic [STALL_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)                         count_d = '0;
        else if (bump && count_q != CNT_MAX) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
    assign warn  = (count_q > CNT_LIM);

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned VEC_W       = 8,
    parameter int unsigned DEST_W      = 8,
    parameter int unsigned STALL_W     = 4,
    parameter int unsigned STALL_LIMIT = 5,
    localparam int unsigned PIN_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        pin_in,
    input  logic                       cfg_write,
    input  logic [NUM_PINS-1:0]        cfg_mask,
    input  logic [NUM_PINS-1:0]        cfg_level,
    input  logic [NUM_PINS-1:0]        cfg_polarity,
    input  logic [NUM_PINS-1:0]        cfg_logical,
    input  logic [3*NUM_PINS-1:0]      cfg_dmode,
    input  logic [VEC_W*NUM_PINS-1:0]  cfg_vector,
    input  logic [DEST_W*NUM_PINS-1:0] cfg_dest,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [PIN_W-1:0]           req_pin,
    output logic [VEC_W-1:0]           req_vector,
    output logic [DEST_W-1:0]          req_dest,
    output logic [2:0]                 req_dmode,
    output logic                       req_logical,
    output logic                       req_polarity,
    output logic                       req_level,
    input  logic                       rsp_valid,
    input  logic                       rsp_accept,
    output logic [NUM_PINS-1:0]        pending,
    output logic [NUM_PINS-1:0]        dlv_status,
    output logic [STALL_W-1:0]         stall_count,
    output logic                       stall_warn,
    output logic                       extint_err
);
    import irq_dispatch_pkg::*;

    localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

    typedef struct packed {
        scan_state_e         st;
        logic [PIN_W-1:0]    idx;
        logic                rescan;
        logic [NUM_PINS-1:0] pend;
        logic [NUM_PINS-1:0] dstat;
        logic                ext_err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_PINS-1:0] rise, fall;
    logic                trigger, advance, stall_inc, stall_clr;
    logic [2:0]          cur_dmode;

    irq_level_track #(.NUM_PINS(NUM_PINS)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    irq_stall_count #(.STALL_W(STALL_W), .STALL_LIMIT(STALL_LIMIT)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (stall_inc),
        .clear (stall_clr),
        .count (stall_count),
        .warn  (stall_warn)
    );

    assign cur_dmode = cfg_dmode[ctl_q.idx*3 +: 3];
    assign trigger   = (|rise) | cfg_write;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.ext_err = 1'b0;
        advance       = 1'b0;
        stall_inc     = 1'b0;
        stall_clr     = 1'b0;

        if (ctl_q.st != ST_IDLE && trigger) ctl_d.rescan = 1'b1;

        case (ctl_q.st)
            ST_IDLE: begin
                if (trigger) begin
                    ctl_d.st  = ST_SCAN;
                    ctl_d.idx = '0;
                end
            end
            ST_SCAN: begin
                if (ctl_q.pend[ctl_q.idx] && !cfg_mask[ctl_q.idx]) begin
                    if (cur_dmode == DMODE_EXTINT) begin
                        ctl_d.ext_err = 1'b1;
                        advance       = 1'b1;
                    end else begin
                        ctl_d.st = ST_REQ;
                    end
                end else begin
                    advance = 1'b1;
                end
            end
            ST_REQ: begin
                if (req_ready) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    advance = 1'b1;
                    if (rsp_accept) begin
                        ctl_d.dstat[ctl_q.idx] = 1'b0;
                        stall_clr              = 1'b1;
                        if (!cfg_level[ctl_q.idx]) ctl_d.pend[ctl_q.idx] = 1'b0;
                    end else begin
                        ctl_d.dstat[ctl_q.idx] = 1'b1;
                        stall_inc              = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (advance) begin
            if (ctl_q.idx == LAST_PIN) begin
                ctl_d.idx    = '0;
                ctl_d.st     = ctl_d.rescan ? ST_SCAN : ST_IDLE;
                ctl_d.rescan = 1'b0;
            end else begin
                ctl_d.idx = ctl_q.idx + 1'b1;
                ctl_d.st  = ST_SCAN;
            end
        end

        // Input events are applied last so a new edge outranks a clear.
        ctl_d.pend = (ctl_d.pend & ~(fall & cfg_level)) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, idx: '0, rescan: 1'b0,
                       pend: '0, dstat: '0, ext_err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_valid    = (ctl_q.st == ST_REQ);
    assign req_pin      = ctl_q.idx;
    assign req_vector   = cfg_vector[ctl_q.idx*VEC_W +: VEC_W];
    assign req_dest     = cfg_dest[ctl_q.idx*DEST_W +: DEST_W];
    assign req_dmode    = cur_dmode;
    assign req_logical  = cfg_logical[ctl_q.idx];
    assign req_polarity = cfg_polarity[ctl_q.idx];
    assign req_level    = cfg_level[ctl_q.idx];
    assign pending      = ctl_q.pend;
    assign dlv_status   = ctl_q.dstat;
    assign extint_err   = ctl_q.ext_err;

endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned STALL_W  = 4,
    parameter int unsigned PIN_W    = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_PINS-1:0]    pin_in,
    input logic [NUM_PINS-1:0]    cfg_mask,
    input logic [NUM_PINS-1:0]    cfg_level,
    input logic [3*NUM_PINS-1:0]  cfg_dmode,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [PIN_W-1:0]       req_pin,
    input logic                   rsp_valid,
    input logic                   rsp_accept,
    input logic [NUM_PINS-1:0]    pending,
    input logic [NUM_PINS-1:0]    dlv_status,
    input logic [STALL_W-1:0]     stall_count,
    input logic                   stall_warn
);

    logic [PIN_W-1:0]    last_pin_q;
    logic [NUM_PINS-1:0] pin_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pin_q <= '0;
            pin_prev_q <= '0;
        end else begin
            last_pin_q <= req_pin;
            pin_prev_q <= pin_in;
        end
    end

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_pin));

    assert_masked_not_sent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !cfg_mask[req_pin]);

    assert_extint_not_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> cfg_dmode[req_pin*3 +: 3] != 3'd7);

    assert_accept_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_accept |=> !dlv_status[last_pin_q] && stall_count == '0 && !stall_warn);

    assert_reject_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_accept |=> dlv_status[last_pin_q] && pending[last_pin_q] && stall_count != '0);

    assert_edge_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_accept && pin_in[req_pin] && !pin_prev_q[req_pin] |=> pending[last_pin_q]);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assert_level_fall_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pin_in[i]) && cfg_level[i] |=> !pending[i]);
        assert_edge_fall_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pin_in[i]) && !cfg_level[i] && pending[i] && !(rsp_valid && req_pin == PIN_W'(i))
            |=> pending[i]);
    end

endmodule

bind irq_dispatch irq_dispatch_checker #(
    .NUM_PINS (NUM_PINS),
    .STALL_W  (STALL_W),
    .PIN_W    (PIN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (pin_in),
    .cfg_mask    (cfg_mask),
    .cfg_level   (cfg_level),
    .cfg_dmode   (cfg_dmode),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_pin     (req_pin),
    .rsp_valid   (rsp_valid),
    .rsp_accept  (rsp_accept),
    .pending     (pending),
    .dlv_status  (dlv_status),
    .stall_count (stall_count),
    .stall_warn  (stall_warn)
);

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;

    localparam int N      = 8;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int SW     = 4;
    localparam int PW     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]        pin_in = '0;
    logic                cfg_write = 1'b0;
    logic [N-1:0]        cfg_mask = '0, cfg_level = '0, cfg_polarity, cfg_logical;
    logic [3*N-1:0]      cfg_dmode;
    logic [VEC_W*N-1:0]  cfg_vector;
    logic [DEST_W*N-1:0] cfg_dest;
    logic [2:0]          dm [N];
    logic                req_valid, req_ready = 1'b1;
    logic [PW-1:0]       req_pin;
    logic [VEC_W-1:0]    req_vector;
    logic [DEST_W-1:0]   req_dest;
    logic [2:0]          req_dmode;
    logic                req_logical, req_polarity, req_level;
    logic                rsp_valid = 1'b0, rsp_accept = 1'b0;
    logic [N-1:0]        pending, dlv_status;
    logic [SW-1:0]       stall_count;
    logic                stall_warn, extint_err;

    int checks = 0;
    int errors = 0;
    int ext_seen = 0;
    int cycles = 0;

    function automatic logic [7:0] exp_vec(int p); return 8'(8'h30 + p * 7); endfunction
    function automatic logic [7:0] exp_dst(int p); return 8'(8'hA0 ^ (p * 3)); endfunction

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cfg_vector[i*VEC_W +: VEC_W] = exp_vec(i);
            cfg_dest[i*DEST_W +: DEST_W] = exp_dst(i);
            cfg_dmode[i*3 +: 3]          = dm[i];
            cfg_logical[i]               = 1'(i & 1);
            cfg_polarity[i]              = 1'((i >> 1) & 1);
        end
    end

    irq_dispatch #(.NUM_PINS(N), .VEC_W(VEC_W), .DEST_W(DEST_W), .STALL_W(SW), .STALL_LIMIT(5)) u_irq_dispatch (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_write(cfg_write),
        .cfg_mask(cfg_mask), .cfg_level(cfg_level), .cfg_polarity(cfg_polarity),
        .cfg_logical(cfg_logical), .cfg_dmode(cfg_dmode), .cfg_vector(cfg_vector),
        .cfg_dest(cfg_dest), .req_valid(req_valid), .req_ready(req_ready),
        .req_pin(req_pin), .req_vector(req_vector), .req_dest(req_dest),
        .req_dmode(req_dmode), .req_logical(req_logical), .req_polarity(req_polarity),
        .req_level(req_level), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .pending(pending), .dlv_status(dlv_status), .stall_count(stall_count),
        .stall_warn(stall_warn), .extint_err(extint_err)
    );

    always @(negedge clk) begin
        if (rst_n && extint_err) ext_seen++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic quiet(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(!req_valid, req, "unexpected request", int'(req_pin), -1);
        end
    endtask

    task automatic pulse_write();
        @(negedge clk); cfg_write = 1'b1;
        @(negedge clk); cfg_write = 1'b0;
    endtask

    // Wait for a request, check its fields, optionally hold ready low, then respond.
    task automatic serve(input int pin, input bit acc, input int hold, input string req);
        int waited = 0;
        @(negedge clk);
        while (!req_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk(req_valid, req, "request seen", int'(req_valid), 1);
        chk(int'(req_pin) == pin, req, "request pin", int'(req_pin), pin);
        chk(req_vector == exp_vec(pin) && req_dest == exp_dst(pin), req, "vector/dest",
            int'({req_vector, req_dest}), int'({exp_vec(pin), exp_dst(pin)}));
        chk(req_dmode == dm[pin] && req_logical == 1'(pin & 1) && req_polarity == 1'((pin >> 1) & 1)
            && req_level == cfg_level[pin], req, "mode fields",
            int'({req_dmode, req_logical, req_polarity, req_level}),
            int'({dm[pin], 1'(pin & 1), 1'((pin >> 1) & 1), cfg_level[pin]}));
        if (hold > 0) begin
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                chk(req_valid && int'(req_pin) == pin, "R11", "request held", int'(req_valid), 1);
            end
            req_ready = 1'b1;
        end
        @(negedge clk);
        rsp_valid = 1'b1; rsp_accept = acc;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_accept = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) dm[i] = 3'(i % 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(pending == '0 && dlv_status == '0, "R1", "pending/status", int'({pending, dlv_status}), 0);
        chk(stall_count == '0 && !stall_warn && !extint_err && !req_valid, "R1", "count/flags",
            int'({stall_count, stall_warn, extint_err, req_valid}), 0);

        // R4: three edge pins rise together, served in ascending order
        pin_in = 8'b0110_0100;
        @(negedge clk);
        chk(pending == 8'b0110_0100, "R4", "pending after rise", int'(pending), 8'b0110_0100);
        serve(2, 1'b1, 0, "R4");
        serve(5, 1'b1, 0, "R4");
        serve(6, 1'b1, 0, "R4");
        chk(pending == '0, "R6", "edge pending cleared on accept", int'(pending), 0);
        pin_in = '0;
        quiet(12, "R3");
        chk(pending == '0, "R3", "no re-arm on fall", int'(pending), 0);

        // R5 / R3 / R9: masked edge pin
        cfg_mask[3] = 1'b1;
        @(negedge clk); pin_in[3] = 1'b1;
        quiet(12, "R5");
        chk(pending[3] == 1'b1, "R5", "masked pin stays pending", int'(pending[3]), 1);
        pin_in[3] = 1'b0;
        quiet(3, "R3");
        chk(pending[3] == 1'b1, "R3", "edge fall keeps pending", int'(pending[3]), 1);
        cfg_mask[3] = 1'b0;
        pulse_write();
        serve(3, 1'b1, 0, "R9");
        chk(pending[3] == 1'b0, "R9", "pending cleared after write scan", int'(pending[3]), 0);

        // R6 / R2: level pin
        cfg_level[4] = 1'b1;
        @(negedge clk); pin_in[4] = 1'b1;
        serve(4, 1'b1, 0, "R6");
        chk(pending[4] == 1'b1, "R6", "level pending kept on accept", int'(pending[4]), 1);
        quiet(10, "R6");
        pin_in[4] = 1'b0;
        @(negedge clk);
        chk(pending[4] == 1'b0, "R2", "level fall clears pending", int'(pending[4]), 0);
        cfg_level[1] = 1'b1; cfg_mask[1] = 1'b1;
        @(negedge clk); pin_in[1] = 1'b1;
        @(negedge clk);
        chk(pending[1] == 1'b1, "R1", "rise sets pending", int'(pending[1]), 1);
        pin_in[1] = 1'b0;
        @(negedge clk);
        chk(pending[1] == 1'b0, "R2", "masked level fall clears", int'(pending[1]), 0);
        quiet(10, "R5");
        cfg_level[1] = 1'b0; cfg_mask[1] = 1'b0;

        // R7: repeated rejects, saturation and warning threshold
        @(negedge clk); pin_in[0] = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            if (k > 1) pulse_write();
            serve(0, 1'b0, 0, "R7");
            chk(dlv_status[0] && pending[0], "R7", "status/pending after reject",
                int'({dlv_status[0], pending[0]}), 3);
            chk(int'(stall_count) == ((k > 15) ? 15 : k), "R7", "retry count",
                int'(stall_count), (k > 15) ? 15 : k);
            chk(stall_warn == (k > 5), "R7", "stall warning", int'(stall_warn), int'(k > 5));
        end
        pulse_write();
        serve(0, 1'b1, 0, "R6");
        chk(!dlv_status[0] && !pending[0] && stall_count == '0 && !stall_warn, "R6",
            "accept clears status/count", int'({dlv_status[0], pending[0], stall_count, stall_warn}), 0);
        pin_in[0] = 1'b0;
        quiet(10, "R6");

        // R8: mode-7 entry is not dispatched
        dm[7] = 3'd7;
        ext_seen = 0;
        @(negedge clk); pin_in[7] = 1'b1;
        quiet(14, "R8");
        chk(ext_seen == 1, "R8", "extint pulses", ext_seen, 1);
        chk(pending[7] == 1'b1, "R8", "mode-7 pin stays pending", int'(pending[7]), 1);
        dm[7] = 3'd1;
        pulse_write();
        serve(7, 1'b1, 0, "R8");
        chk(pending[7] == 1'b0, "R8", "served after mode change", int'(pending[7]), 0);
        pin_in[7] = 1'b0;

        // R11: ready held low
        req_ready = 1'b0;
        @(negedge clk); pin_in[2] = 1'b1;
        serve(2, 1'b1, 4, "R11");
        chk(pending[2] == 1'b0, "R11", "served after stall", int'(pending[2]), 0);
        pin_in[2] = 1'b0;
        quiet(10, "R11");

        // R10: new edge collides with accept of the same edge pin
        @(negedge clk); pin_in[1] = 1'b1;
        begin
            int waited = 0;
            @(negedge clk);
            while (!req_valid && waited < 200) begin @(negedge clk); waited++; end
        end
        chk(req_valid && req_pin == 3'd1, "R10", "first request", int'(req_pin), 1);
        pin_in[1] = 1'b0;
        @(negedge clk);
        pin_in[1] = 1'b1; rsp_valid = 1'b1; rsp_accept = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_accept = 1'b0;
        chk(pending[1] == 1'b1, "R10", "pending survives collision", int'(pending[1]), 1);
        serve(1, 1'b1, 0, "R10");
        chk(pending[1] == 1'b0, "R10", "second delivery clears", int'(pending[1]), 0);
        quiet(12, "R10");

        finish_run();
    end

endmodule